// File: doc/BRIEF.md
# Two-Step Time Converter Sequencer and Encoder

This block is the clocked control and encoding logic that sits behind a two-step coarse/fine vernier time measurement front end. A trigger starts one conversion. During the coarse phase the block drives the stop-path delay control word to all ones. The coarse chain's start and stop lines then fall, which ends the coarse phase. At that moment the block freezes the coarse thermometer result and turns it into a narrower delay control word for the fine phase. It then enables the fine chain.

When the fine chain's start and stop lines have both fallen, the block freezes the fine thermometer result. In the next cycle it emits one binary code with a one-cycle valid strobe. The coarse count carries a weight of nine fine steps, so the code spans 0 to 44. The inputs carry timing only on their rising edges. The block watches falling edges only as a sign that a chain has finished. A thermometer input with a gap in its ones is decoded by its run of ones from the bottom, and this sets a sticky error flag.

Top module: `tdc2_seq`

## Requirements
- R1: After a synchronous reset, `crs_en_o`, `fine_en_o`, `valid_o`, `bubble_err_o` and `result_o` are all zero, and `dly_ctl_o` is 4'b1111.
- R2: A `trig_i` high in the idle state raises `crs_en_o` on the next clock edge. While `crs_en_o` is high, `dly_ctl_o` stays 4'b1111.
- R3: The coarse phase ends on the edge where both `crs_start_i` and `crs_stop_i` have been seen to fall (high to low) since the phase began. The two falls may happen in either order and in different cycles. At that edge `crs_en_o` drops and `fine_en_o` rises.
- R4: During the fine phase, `dly_ctl_o` holds a mask whose lowest k−1 bits are 1 and whose other bits are 0. Here k is the number of consecutive ones counted from bit 0 of the captured coarse code. If k is 0, the mask is 4'b0000.
- R5: The fine phase ends on the edge where both `fin_start_i` and `fin_stop_i` have been seen to fall during the fine phase. At that edge `fine_en_o` drops.
- R6: One cycle after `fine_en_o` falls, `valid_o` is high for exactly one cycle. At the same time `result_o` = 9 × kc + kf, where kc and kf are the counts of ones from bit 0 of the coarse and fine codes.
- R7: Each thermometer code is captured on the edge that ends its phase. Later changes on `crs_therm_i` or `fin_therm_i` do not alter that conversion's result.
- R8: A code with a 1 above its first 0 is decoded by its bottom run of ones. It also sets `bubble_err_o`, which stays high until reset.
- R9: A `trig_i` that arrives during a conversion is ignored. It starts no new coarse phase and produces no extra result.
- R10: Falls on the fine start/stop lines that happen outside the fine phase do not end the fine phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Measurement trigger |
| crs_start_i | input | 1 | Coarse chain start line |
| crs_stop_i | input | 1 | Coarse chain stop line |
| crs_therm_i | input | 4 | Coarse thermometer code |
| fin_start_i | input | 1 | Fine chain start line |
| fin_stop_i | input | 1 | Fine chain stop line |
| fin_therm_i | input | 8 | Fine thermometer code |
| crs_en_o | output | 1 | Coarse phase active |
| fine_en_o | output | 1 | Fine phase active |
| dly_ctl_o | output | 4 | Stop-path delay control word |
| result_o | output | 6 | Binary conversion result |
| valid_o | output | 1 | One-cycle result strobe |
| bubble_err_o | output | 1 | Sticky non-contiguous code flag |

## Verification
The hardest case to reach is a phase end that depends on the past. One example is a staggered pair of falls, where only the second fall completes the phase. Another is a fine-line fall that comes too early, while the coarse phase is still running. The stimulus produces both on purpose. It drops the coarse start line one cycle before the stop line. It also toggles the fine lines during the coarse phase, then checks that the fine phase is still open afterwards. The same conversion scrambles the thermometer inputs after capture, and the scoreboard confirms that the frozen counts are used.

// File: rtl/tdc2_pkg.sv
package tdc2_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COARSE = 2'd1,
    ST_FINE   = 2'd2,
    ST_ENCODE = 2'd3
  } tdc2_state_e;
endpackage

// File: rtl/tdc2_therm_dec.sv
// Counts the run of ones from bit 0 and flags any 1 above that run.
module tdc2_therm_dec #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  code_i,
  output logic [CW-1:0] ones_o,
  output logic          bubble_o
);
  logic          run;
  logic [CW-1:0] cnt;

  always_comb begin
    run = 1'b1;
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      if (run && code_i[i]) cnt = cnt + 1'b1;
      else                  run = 1'b0;
    end
  end

  always_comb begin
    bubble_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (code_i[i] && (i >= int'(cnt))) bubble_o = 1'b1;
    end
  end

  assign ones_o = cnt;

  always_comb begin
    assert_count_bound_R8: assert (int'(ones_o) <= W);
  end
endmodule

// File: rtl/tdc2_fall_pair.sv
// Remembers falls on two lines while armed; done when both have fallen.
module tdc2_fall_pair (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic a_i,
  input  logic b_i,
  output logic done_o
);
  logic a_q, b_q, seen_a_q, seen_b_q;
  logic fell_a, fell_b;

  assign fell_a = a_q & ~a_i;
  assign fell_b = b_q & ~b_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q      <= 1'b0;
      b_q      <= 1'b0;
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else begin
      a_q      <= a_i;
      b_q      <= b_i;
      seen_a_q <= arm_i & ~done_o & (seen_a_q | fell_a);
      seen_b_q <= arm_i & ~done_o & (seen_b_q | fell_b);
    end
  end

  assign done_o = arm_i & (seen_a_q | fell_a) & (seen_b_q | fell_b);

  assert_seen_needs_arm_R10: assert property (@(posedge clk) disable iff (rst)
    (seen_a_q | seen_b_q) |-> $past(arm_i));
endmodule

// File: rtl/tdc2_seq.sv
module tdc2_seq
  import tdc2_pkg::*;
#(
  parameter int CRS_STAGES = 4,
  parameter int FIN_STAGES = 8,
  parameter int CRS_WEIGHT = 9,
  localparam int CRS_CW  = $clog2(CRS_STAGES + 1),
  localparam int FIN_CW  = $clog2(FIN_STAGES + 1),
  localparam int RES_MAX = CRS_WEIGHT * CRS_STAGES + FIN_STAGES,
  localparam int RES_W   = $clog2(RES_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  trig_i,
  input  logic                  crs_start_i,
  input  logic                  crs_stop_i,
  input  logic [CRS_STAGES-1:0] crs_therm_i,
  input  logic                  fin_start_i,
  input  logic                  fin_stop_i,
  input  logic [FIN_STAGES-1:0] fin_therm_i,
  output logic                  crs_en_o,
  output logic                  fine_en_o,
  output logic [CRS_STAGES-1:0] dly_ctl_o,
  output logic [RES_W-1:0]      result_o,
  output logic                  valid_o,
  output logic                  bubble_err_o
);
  tdc2_state_e state_q;

  logic [CRS_CW-1:0]     crs_ones, crs_cnt_q;
  logic [FIN_CW-1:0]     fin_ones, fin_cnt_q;
  logic                  crs_bub, fin_bub;
  logic                  crs_done, fin_done;
  logic [CRS_STAGES-1:0] fine_mask;

  tdc2_therm_dec #(.W(CRS_STAGES), .CW(CRS_CW)) u_crs_dec (
    .code_i(crs_therm_i), .ones_o(crs_ones), .bubble_o(crs_bub));

  tdc2_therm_dec #(.W(FIN_STAGES), .CW(FIN_CW)) u_fin_dec (
    .code_i(fin_therm_i), .ones_o(fin_ones), .bubble_o(fin_bub));

  tdc2_fall_pair u_crs_fall (
    .clk(clk), .rst(rst), .arm_i(state_q == ST_COARSE),
    .a_i(crs_start_i), .b_i(crs_stop_i), .done_o(crs_done));

  tdc2_fall_pair u_fin_fall (
    .clk(clk), .rst(rst), .arm_i(state_q == ST_FINE),
    .a_i(fin_start_i), .b_i(fin_stop_i), .done_o(fin_done));

  // Fine-phase control: keep the lowest (k-1) bits of the coarse count set.
  genvar g;
  generate
    for (g = 0; g < CRS_STAGES; g++) begin : g_mask
      assign fine_mask[g] = (g + 1) < int'(crs_ones);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      crs_en_o     <= 1'b0;
      fine_en_o    <= 1'b0;
      dly_ctl_o    <= '1;
      result_o     <= '0;
      valid_o      <= 1'b0;
      bubble_err_o <= 1'b0;
      crs_cnt_q    <= '0;
      fin_cnt_q    <= '0;
    end else begin
      valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          dly_ctl_o <= '1;
          if (trig_i) begin
            state_q  <= ST_COARSE;
            crs_en_o <= 1'b1;
          end
        end
        ST_COARSE: begin
          if (crs_done) begin
            crs_cnt_q <= crs_ones;
            dly_ctl_o <= fine_mask;
            crs_en_o  <= 1'b0;
            fine_en_o <= 1'b1;
            state_q   <= ST_FINE;
            if (crs_bub) bubble_err_o <= 1'b1;
          end
        end
        ST_FINE: begin
          if (fin_done) begin
            fin_cnt_q <= fin_ones;
            fine_en_o <= 1'b0;
            state_q   <= ST_ENCODE;
            if (fin_bub) bubble_err_o <= 1'b1;
          end
        end
        ST_ENCODE: begin
          result_o  <= RES_W'(CRS_WEIGHT * int'(crs_cnt_q) + int'(fin_cnt_q));
          valid_o   <= 1'b1;
          dly_ctl_o <= '1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_ctl_max_in_coarse_R2: assert property (@(posedge clk) disable iff (rst)
    crs_en_o |-> (dly_ctl_o == '1));
  assert_phases_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(crs_en_o && fine_en_o));
  assert_coarse_to_fine_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(crs_en_o) |-> fine_en_o);
  assert_fine_mask_top_clear_R4: assert property (@(posedge clk) disable iff (rst)
    fine_en_o |-> !dly_ctl_o[CRS_STAGES-1]);
  assert_valid_after_fine_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(fine_en_o) |=> valid_o);
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  assert_result_range_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (int'(result_o) <= RES_MAX));
  assert_bubble_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    bubble_err_o |=> bubble_err_o);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (fine_en_o && trig_i) |=> !crs_en_o);
endmodule

// File: tb/tdc2_seq_tb.sv
module tdc2_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig = 1'b0;
  logic       cst = 1'b0, csp = 1'b0, fst = 1'b0, fsp = 1'b0;
  logic [3:0] cth = '0;
  logic [7:0] fth = '0;
  logic       crs_en, fine_en, valid, bub;
  logic [3:0] dctl;
  logic [5:0] res;

  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  bit exp_bub = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tdc2_seq u_dut (
    .clk(clk), .rst(rst), .trig_i(trig),
    .crs_start_i(cst), .crs_stop_i(csp), .crs_therm_i(cth),
    .fin_start_i(fst), .fin_stop_i(fsp), .fin_therm_i(fth),
    .crs_en_o(crs_en), .fine_en_o(fine_en), .dly_ctl_o(dctl),
    .result_o(res), .valid_o(valid), .bubble_err_o(bub));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int run1(input logic [7:0] v, input int w);
    int n = 0;
    while (n < w && v[n]) n++;
    return n;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R6/R9 unexpected valid", res, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(res == e, "R6/R7 result", res, e);
      end
    end
  end

  task automatic conv(input logic [3:0] c, input logic [7:0] f,
                      input bit stagger, input bit trig_mid, input bit disturb);
    int kc, kf, m;
    kc = run1({4'b0, c}, 4);
    kf = run1(f, 8);
    m  = (kc > 0) ? ((1 << (kc - 1)) - 1) : 0;
    if (c != 4'((1 << kc) - 1) || f != 8'((1 << kf) - 1)) exp_bub = 1'b1;
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    chk(crs_en == 1'b1, "R2 crs_en", crs_en, 1);
    chk(dctl == 4'hF, "R2 ctl max", dctl, 15);
    cst = 1'b1; csp = 1'b1;
    if (disturb) begin fst = 1'b1; fsp = 1'b1; end
    @(negedge clk) cth = c;
    if (disturb) begin fst = 1'b0; fsp = 1'b0; end
    if (stagger) begin
      cst = 1'b0;
      @(negedge clk);
      chk(crs_en == 1'b1 && fine_en == 1'b0, "R3 one fall only", fine_en, 0);
      chk(dctl == 4'hF, "R2 ctl max held", dctl, 15);
      csp = 1'b0;
    end else begin
      cst = 1'b0; csp = 1'b0;
    end
    @(negedge clk);
    chk(fine_en == 1'b1 && crs_en == 1'b0, "R3 fine entered", fine_en, 1);
    chk(dctl == 4'(m), "R4 fine mask", dctl, m);
    if (disturb) begin
      cth = ~c;
      @(negedge clk);
      chk(fine_en == 1'b1, "R10 early fine falls ignored", fine_en, 1);
    end
    if (trig_mid) begin
      trig = 1'b1;
      @(negedge clk) trig = 1'b0;
      chk(crs_en == 1'b0 && fine_en == 1'b1, "R9 trig ignored", crs_en, 0);
    end
    fst = 1'b1; fsp = 1'b1;
    @(negedge clk) fth = f; fst = 1'b0; fsp = 1'b0;
    exp_q.push_back(9 * kc + kf);
    @(negedge clk);
    chk(fine_en == 1'b0, "R5 fine ended", fine_en, 0);
    fth = ~f;
    @(negedge clk);
    @(negedge clk);
    chk(bub == exp_bub, "R8 bubble flag", bub, exp_bub);
    chk(crs_en == 1'b0, "R9 no extra phase", crs_en, 0);
  endtask

  initial begin : wd
    repeat (5000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(crs_en == 0 && fine_en == 0 && valid == 0, "R1 reset flags", crs_en, 0);
    chk(bub == 0 && res == 0, "R1 reset result", res, 0);
    chk(dctl == 4'hF, "R1 reset ctl", dctl, 15);
    conv(4'b0011, 8'b0001_1111, 1'b0, 1'b0, 1'b0);   // 23
    conv(4'b1111, 8'b1111_1111, 1'b0, 1'b1, 1'b0);   // 44
    conv(4'b0000, 8'b0000_0000, 1'b0, 1'b0, 1'b1);   // 0
    conv(4'b0001, 8'b0000_0001, 1'b1, 1'b0, 1'b1);   // 10
    conv(4'b0101, 8'b0000_1011, 1'b0, 1'b0, 1'b0);   // 11, bubble
    conv(4'b0111, 8'b0011_1111, 1'b1, 1'b1, 1'b0);   // 33, bubble stays
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 results outstanding", exp_q.size(), 0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule